// File: doc/BRIEF.md
# Byte-Lane Static Memory Array

This block is a clocked, synthesizable model of a 16-bit static memory that has two byte lanes and a selectable 8-bit mode. It is meant for simulation and for prototype fabrics that need such a memory without real tristate pins. Data enters on `d_in` and leaves on `d_out`. Two lane flags in `d_oe` say which halves of `d_out` are being driven.

Access is gated by two chip selects of opposite polarity: `cs_n` must be low and `cs_hi` must be high. Writes take effect on a rising clock edge. A read returns data one cycle after its controls and address are sampled.

In word mode, `lb_n` and `ub_n` choose the active lanes. When `byte_n` is low the block runs in byte mode. Bit 15 of `d_in` then becomes the lowest address bit and chooses one half of the stored word. Only bits 7:0 carry data in byte mode, and the byte selects are ignored.

Top module: `bytelane_sram`

## Requirements
- R1: When the block is not selected (`cs_n` high or `cs_hi` low), `d_oe` is 0 in the cycle after sampling and the array is not written.
- R2: A word-mode read (selected, `we_n` high, `oe_n` low, `byte_n` high) sets `d_oe[0]` (bits 7:0) when `lb_n` is low and `d_oe[1]` (bits 15:8) when `ub_n` is low. Either lane or both may be set.
- R3: A word-mode write (selected, `we_n` low) stores `d_in[7:0]` only if `lb_n` is low and `d_in[15:8]` only if `ub_n` is low. A lane whose select is high keeps its old value.
- R4: In word mode with both `lb_n` and `ub_n` high, no lane is driven, even when `oe_n` is low.
- R5: When selected with `we_n` high and `oe_n` high, `d_oe` is 0 and the array keeps its contents.
- R6: In byte mode, bit 15 of `d_in` is an address bit and only bits 7:0 carry data. `d_oe[1]` stays 0.
- R7: In byte mode the byte selects have no effect. `d_in[15]`=0 chooses stored bits 7:0 and `d_in[15]`=1 chooses stored bits 15:8, for both read and write. Read data appears on `d_out[7:0]` with `d_oe`=01.
- R8: Write takes priority over output enable. While `we_n` is low, the next `d_oe` is 0.
- R9: Read data is valid on `d_out` in the cycle after the read is sampled. A read reflects every write completed on earlier edges.
- R10: While `rst_n` is low, `d_oe` and `d_out` are 0. The array contents are not cleared by reset.
- R11: Any lane whose `d_oe` flag is 0 drives zeros on its `d_out` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower lane select, active low (word mode) |
| ub_n | input | 1 | Upper lane select, active low (word mode) |
| byte_n | input | 1 | Byte-mode strap, low selects 8-bit mode |
| addr | input | ADDR_W | Word address |
| d_in | input | 16 | Write data; bit 15 is the half-select address bit in byte mode |
| d_out | output | 16 | Read data |
| d_oe | output | 2 | Lane drive flags: bit 0 for bits 7:0, bit 1 for bits 15:8 |

## Verification
The assertions assume that every control input is a clean 0 or 1 at each rising edge. They also assume that `byte_n` is treated as a static strap while a read is in flight, so the mode seen at an output is the mode of the cycle that sampled the read. The stimulus changes every input only on falling edges. Its random addresses are limited to a small window that is fully written before any read, so every read has a defined expected word. Each mode's read and write paths are exercised on that window, including word-mode writes with both selects high and output-disable cycles that carry stray data.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANE_W  = 8;
  localparam int NLANES  = 2;
  localparam int WORD_W  = LANE_W * NLANES;

  typedef logic [NLANES-1:0] lane_mask_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_op_decode.sv
module sram_op_decode
  import sram_pkg::*;
(
  input  logic              cs_n,
  input  logic              cs_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic              byte_n,
  input  logic [WORD_W-1:0] d_in,
  output op_e               op,
  output lane_mask_t        wr_mask,
  output lane_mask_t        rd_mask,
  output logic [WORD_W-1:0] wr_data,
  output logic              half
);
  logic       selected;
  lane_mask_t word_lanes;
  lane_mask_t byte_lanes;
  lane_mask_t act_lanes;

  assign selected   = !cs_n && cs_hi;
  assign half       = !byte_n && d_in[WORD_W-1];
  assign word_lanes = ~{ub_n, lb_n};
  assign byte_lanes = half ? lane_mask_t'(2'b10) : lane_mask_t'(2'b01);
  assign act_lanes  = byte_n ? word_lanes : byte_lanes;

  always_comb begin
    op = OP_IDLE;
    if (selected) begin
      if (!we_n)      op = OP_WRITE;
      else if (!oe_n) op = OP_READ;
    end
  end

  // write data: byte mode replicates the low byte to both lanes
  always_comb begin
    if (byte_n) wr_data = d_in;
    else        wr_data = {d_in[LANE_W-1:0], d_in[LANE_W-1:0]};
  end

  assign wr_mask = (op == OP_WRITE) ? act_lanes : '0;
  // byte mode reads always drive only the low lane
  assign rd_mask = (op != OP_READ) ? '0 :
                   (byte_n ? word_lanes : lane_mask_t'(2'b01));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  lane_mask_t        wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lane_mask_t        rd_mask,
  input  logic              byte_mode,
  input  logic              half,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] d_out,
  output lane_mask_t        d_oe
);
  lane_mask_t en_d, en_q;
  logic       hi_d, hi_q;

  always_comb begin
    en_d = rd_mask;
    hi_d = byte_mode && half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      hi_q <= 1'b0;
    end else begin
      en_q <= en_d;
      hi_q <= hi_d;
    end
  end

  logic [LANE_W-1:0] low_src;
  assign low_src = hi_q ? rd_data[WORD_W-1:LANE_W] : rd_data[LANE_W-1:0];

  always_comb begin
    d_out = '0;
    if (en_q[0]) d_out[LANE_W-1:0]      = low_src;
    if (en_q[1]) d_out[WORD_W-1:LANE_W] = rd_data[WORD_W-1:LANE_W];
  end

  assign d_oe = en_q;
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic              byte_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       d_in,
  output logic [15:0]       d_out,
  output logic [1:0]        d_oe
);
  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  op_e               op;
  lane_mask_t        wr_mask, rd_mask;
  logic [WORD_W-1:0] wr_data, rd_data;
  logic              half;
  lane_mask_t        oe_lanes;

  sram_op_decode u_dec (
    .cs_n    (cs_n),
    .cs_hi   (cs_hi),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .lb_n    (lb_n),
    .ub_n    (ub_n),
    .byte_n  (byte_n),
    .d_in    (d_in),
    .op      (op),
    .wr_mask (wr_mask),
    .rd_mask (rd_mask),
    .wr_data (wr_data),
    .half    (half)
  );

  sram_lane_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .addr    (addr),
    .wr_mask (wr_mask),
    .wr_data (wr_data),
    .rd_en   (op == OP_READ),
    .rd_data (rd_data)
  );

  sram_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .rd_mask   (rd_mask),
    .byte_mode (!byte_n),
    .half      (half),
    .rd_data   (rd_data),
    .d_out     (d_out),
    .d_oe      (oe_lanes)
  );

  assign d_oe = oe_lanes;
endmodule

// File: rtl/sram_props.sv
module sram_props (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        cs_hi,
  input logic        we_n,
  input logic        oe_n,
  input logic        lb_n,
  input logic        ub_n,
  input logic        byte_n,
  input logic [15:0] d_out,
  input logic [1:0]  d_oe
);
  logic sel;
  assign sel = !cs_n && cs_hi;

  assert_standby_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> d_oe == 2'b00);

  assert_word_read_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we_n && !oe_n && byte_n) |=> d_oe == ~$past({ub_n, lb_n}));

  assert_no_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && byte_n && lb_n && ub_n) |=> d_oe == 2'b00);

  assert_out_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we_n && oe_n) |=> d_oe == 2'b00);

  assert_byte_upper_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_n |=> !d_oe[1]);

  assert_byte_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we_n && !oe_n && !byte_n) |=> d_oe == 2'b01);

  assert_write_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> d_oe == 2'b00);

  assert_low_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !d_oe[0] |-> d_out[7:0] == 8'h00);

  assert_high_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !d_oe[1] |-> d_out[15:8] == 8'h00);
endmodule

bind bytelane_sram sram_props u_props (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .cs_n   (cs_n),
  .cs_hi  (cs_hi),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .lb_n   (lb_n),
  .ub_n   (ub_n),
  .byte_n (byte_n),
  .d_out  (d_out),
  .d_oe   (d_oe)
);

// File: tb/tb_bytelane_sram.sv
module tb_bytelane_sram;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, cs_hi, we_n, oe_n, lb_n, ub_n, byte_n;
  logic [AW-1:0] addr;
  logic [15:0]   d_in;
  logic [15:0]   d_out;
  logic [1:0]    d_oe;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  logic [15:0] shadow [1<<AW];

  always #4 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .we_n(we_n),
    .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .byte_n(byte_n), .addr(addr),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  task automatic check(string req, logic [1:0] oe_exp, logic [15:0] dat_exp);
    vecs++;
    if (d_oe !== oe_exp || d_out !== dat_exp) begin
      errs++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
               req, d_oe, d_out, oe_exp, dat_exp);
    end
  endtask

  // one access: drive on falling edge, sample just after the next rising edge
  task automatic apply(input bit c_n, input bit c_hi, input bit w_n,
                       input bit o_n, input bit l_n, input bit u_n,
                       input bit b_n, input int a, input logic [15:0] din,
                       input string req);
    logic [1:0]  e_oe;
    logic [15:0] e_dat, w;
    string       tag;
    bit          h;
    @(negedge clk);
    cs_n = c_n; cs_hi = c_hi; we_n = w_n; oe_n = o_n;
    lb_n = l_n; ub_n = u_n; byte_n = b_n; addr = AW'(a); d_in = din;
    e_oe = 2'b00; e_dat = 16'h0;
    w = shadow[a];
    h = din[15];
    if (!(!c_n && c_hi)) tag = "R1";
    else if (!w_n) begin
      tag = "R8";
      if (!b_n) begin
        if (h) w[15:8] = din[7:0]; else w[7:0] = din[7:0];
      end else begin
        if (!l_n) w[7:0]  = din[7:0];
        if (!u_n) w[15:8] = din[15:8];
      end
    end else if (o_n) tag = "R5";
    else if (!b_n) begin
      tag = "R7";
      e_oe = 2'b01;
      e_dat[7:0] = h ? w[15:8] : w[7:0];
    end else begin
      tag = (l_n && u_n) ? "R4" : "R2";
      e_oe = {!u_n, !l_n};
      if (!l_n) e_dat[7:0]  = w[7:0];
      if (!u_n) e_dat[15:8] = w[15:8];
    end
    @(posedge clk);
    #2;
    check((req != "") ? req : tag, e_oe, e_dat);
    shadow[a] = w;
  endtask

  task automatic idle();
    apply(1, 0, 1, 1, 1, 1, 1, 0, 16'h0, "R1");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: oe=%b data=%h expected run to complete", d_oe, d_out);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd24680);
    rst_n = 0; cs_n = 1; cs_hi = 0; we_n = 1; oe_n = 1;
    lb_n = 1; ub_n = 1; byte_n = 1; addr = '0; d_in = '0;
    repeat (3) @(posedge clk);
    #2 check("R10", 2'b00, 16'h0);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // fill the window with known words
    for (int i = 0; i < 16; i++) apply(0, 1, 0, 1, 0, 0, 1, i, 16'(16'h1111 * i + 16'h0A05), "R3");

    // R9: full read returns the word on the next cycle
    apply(0, 1, 1, 0, 0, 0, 1, 3, 16'h0, "R9");
    // R2: each lane alone
    apply(0, 1, 1, 0, 0, 1, 1, 3, 16'h0, "R2");
    apply(0, 1, 1, 0, 1, 0, 1, 3, 16'h0, "R2");
    // R4: no lane even with oe_n low
    apply(0, 1, 1, 0, 1, 1, 1, 3, 16'h0, "R4");
    // R3: upper-only write, then full read
    apply(0, 1, 0, 1, 1, 0, 1, 5, 16'hBEEF, "R3");
    apply(0, 1, 1, 0, 0, 0, 1, 5, 16'h0, "R3");
    // R3: write with both selects high changes nothing
    apply(0, 1, 0, 0, 1, 1, 1, 6, 16'hDEAD, "R3");
    apply(0, 1, 1, 0, 0, 0, 1, 6, 16'h0, "R3");
    // R5: output disable with stray data leaves the array intact
    apply(0, 1, 1, 1, 0, 0, 1, 7, 16'hFFFF, "R5");
    apply(0, 1, 1, 0, 0, 0, 1, 7, 16'h0, "R5");
    // R1: each select alone deselects
    apply(1, 1, 0, 0, 0, 0, 1, 8, 16'h1234, "R1");
    apply(0, 0, 0, 0, 0, 0, 1, 8, 16'h1234, "R1");
    apply(0, 1, 1, 0, 0, 0, 1, 8, 16'h0, "R1");
    // R8: write with oe_n low drives nothing
    apply(0, 1, 0, 0, 0, 0, 1, 9, 16'h5A5A, "R8");
    // R7/R6: byte mode writes to each half, selects held high
    apply(0, 1, 0, 1, 1, 1, 0, 10, 16'h80C3, "R7");
    apply(0, 1, 0, 1, 1, 1, 0, 10, 16'h7F3C, "R6");
    apply(0, 1, 1, 0, 1, 1, 0, 10, 16'h8000, "R7");
    apply(0, 1, 1, 0, 0, 0, 0, 10, 16'h0000, "R6");
    apply(0, 1, 1, 0, 0, 0, 1, 10, 16'h0, "R7");
    // R10: reset mid-run forces outputs off, contents survive
    apply(0, 1, 1, 0, 0, 0, 1, 11, 16'h0, "R9");
    @(negedge clk) rst_n = 0;
    #1 check("R10", 2'b00, 16'h0);
    @(negedge clk) rst_n = 1;
    repeat (3) idle();
    apply(0, 1, 1, 0, 0, 0, 1, 11, 16'h0, "R10");
    idle();
    // R11 is covered by every check: disabled lanes must compare as zero

    for (int n = 0; n < 4000; n++) begin
      apply(($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 3) == 0,
            ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
            ($urandom % 4) != 0, $urandom % 16, 16'($urandom), "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule